// File: doc/BRIEF.md
# Zoned Page-Write Memory Controller

This block sits between a serial command front end and a 1-Kbyte user memory. The memory is split into eight protection zones of 128 bytes. The zone of an address is its top three bits, addr[9:7]. The front end opens a write with a start pulse and an address, streams between zero and any number of bytes, and closes the write with an end pulse. The controller gathers those bytes in a 16-byte page buffer. Once the write is closed, it commits the page to the array during a self-timed write cycle, and it raises `busy` for the whole of that cycle.

Reads are single-byte requests, and their result appears one cycle after the request. A configuration input gives a read-enable bit and a write-enable bit for each zone; bit z of each vector belongs to zone z. A write aimed at a zone that is not writable is dropped and flagged. A read from a zone that is not readable returns a fixed fill byte and is flagged.

While the write cycle runs, the controller refuses new commands. The length of the cycle is a parameter counted in clock cycles. The default is 5 ms at 50 MHz, and the value must be at least 16.

Top module: `zpw_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `busy`, `rd_valid`, `rd_err` and `wr_err` are all 0.
- R2: A single-byte write to a zone whose bit in `cfg_wr_en` is 1 stores the byte. A later read of that address from a zone whose bit in `cfg_rd_en` is 1 returns the byte with `rd_err` = 0.
- R3: In a page write, byte k lands at the page base (addr[9:4]) plus ((addr[3:0] + k) mod 16). The offset wraps inside the 16-byte page, and addr[9:4] never changes during the write.
- R4: Page positions that receive no byte during a write keep their earlier contents.
- R5: `busy` rises in the cycle after the `wr_end` pulse of a write that carried at least one byte. It stays high for exactly WR_CYCLES cycles.
- R6: While `busy` is 1, `rd_req` and `wr_start` are ignored. No `rd_valid` and no `wr_err` follow, and memory contents do not change.
- R7: A `wr_start` to a zone whose `cfg_wr_en` bit is 0 pulses `wr_err` for one cycle, in the cycle after the start. The bytes that follow are discarded, and no write cycle starts.
- R8: A read from a zone whose `cfg_rd_en` bit is 0 gives `rd_valid` = 1, `rd_err` = 1 and `rd_data` = RD_FILL (default 8'hFF).
- R9: A write closed with no bytes returns to idle without a write cycle and without an error.
- R10: When more than 16 bytes are sent, each byte past the sixteenth overwrites the earlier byte at the same page offset.
- R11: An accepted read gives `rd_valid` for exactly one cycle, in the cycle right after `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Opens a write at `wr_addr` |
| wr_addr | input | 10 | Start address of the write |
| wr_byte_valid | input | 1 | `wr_byte` carries a data byte |
| wr_byte | input | 8 | Write data byte |
| wr_end | input | 1 | Closes the write and starts the commit |
| rd_req | input | 1 | Single-byte read request |
| rd_addr | input | 10 | Read address |
| cfg_rd_en | input | 8 | Per-zone read permission, bit z for zone z |
| cfg_wr_en | input | 8 | Per-zone write permission, bit z for zone z |
| busy | output | 1 | Write cycle in progress |
| wr_err | output | 1 | One-cycle pulse when a write to a protected zone is rejected |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read data, or RD_FILL when the zone is read-protected |
| rd_err | output | 1 | The current read was refused by zone protection |

## Verification
The hardest behaviour to reach from the ports is the refusal of commands during the write cycle. A command must arrive while `busy` is high, and the bench must then show that the command had no lasting effect. The stimulus opens a page write and, right after `busy` rises, issues a read, a start aimed at a protected zone, and a complete write to an address whose contents the bench already knows. After the cycle ends, reading that address back shows that the refused write left it untouched. Offset wrap and overwrite beyond sixteen bytes are reached with write bursts that start near the end of a page.

// File: rtl/zpw_pkg.sv
package zpw_pkg;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 8;
    localparam int ZONE_W     = 3;
    localparam int PAGE_W     = 4;
    localparam int ZONES      = 1 << ZONE_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_NUM_W = ADDR_W - PAGE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ZONES-1:0]  zone_mask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_COMMIT
    } wr_state_e;

    typedef struct packed {
        logic [PAGE_NUM_W-1:0] page;
        logic [PAGE_W-1:0]     off;
    } page_ptr_t;

    function automatic logic [ZONE_W-1:0] zone_of(addr_t a);
        return a[ADDR_W-1 -: ZONE_W];
    endfunction
endpackage

// File: rtl/zpw_rights.sv
module zpw_rights
    import zpw_pkg::*;
(
    input  addr_t      addr,
    input  zone_mask_t allow,
    output logic       ok
);
    always_comb begin
        ok = allow[zone_of(addr)];
    end
endmodule

// File: rtl/zpw_page_buf.sv
module zpw_page_buf #(
    parameter int PW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_off,
    output logic [DW-1:0] rd_data,
    output logic          rd_mark
);
    localparam int N = 1 << PW;

    logic [DW-1:0] slots [N];
    logic [N-1:0]  mark;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_off] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mark <= '0;
        end else if (wr_en) begin
            mark[wr_off] <= 1'b1;
        end
    end

    assign rd_data = slots[rd_off];
    assign rd_mark = mark[rd_off];
endmodule

// File: rtl/zpw_array.sv
module zpw_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/zpw_ctrl.sv
module zpw_ctrl
    import zpw_pkg::*;
#(
    parameter int                WR_CYCLES = 250000,
    parameter logic [DATA_W-1:0] RD_FILL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_byte_valid,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              wr_end,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ZONES-1:0]  cfg_rd_en,
    input  logic [ZONES-1:0]  cfg_wr_en,
    output logic              busy,
    output logic              wr_err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    localparam int TMR_W = $clog2(WR_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WR_CYCLES - 1);
    localparam logic [TMR_W-1:0] TMR_PAGE = TMR_W'(PAGE_BYTES);

    wr_state_e  st;
    page_ptr_t  ptr;
    logic [TMR_W-1:0] tmr;
    logic       have_bytes;
    logic       wr_ok, rd_ok;
    logic       buf_clr, buf_we, buf_mark;
    byte_t      buf_q, ram_q;
    logic       ram_we, ram_re;
    logic [PAGE_W-1:0] commit_off;

    zpw_rights u_wr_rights (.addr(wr_addr), .allow(cfg_wr_en), .ok(wr_ok));
    zpw_rights u_rd_rights (.addr(rd_addr), .allow(cfg_rd_en), .ok(rd_ok));

    assign commit_off = tmr[PAGE_W-1:0];
    assign buf_clr    = (st == ST_IDLE) && wr_start && wr_ok;
    assign buf_we     = (st == ST_FILL) && wr_byte_valid;

    zpw_page_buf #(.PW(PAGE_W), .DW(DATA_W)) u_page_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (buf_clr),
        .wr_en   (buf_we),
        .wr_off  (ptr.off),
        .wr_data (wr_byte),
        .rd_off  (commit_off),
        .rd_data (buf_q),
        .rd_mark (buf_mark)
    );

    assign ram_we = (st == ST_COMMIT) && (tmr < TMR_PAGE) && buf_mark;
    assign ram_re = (st == ST_IDLE) && rd_req && !wr_start;

    zpw_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk   (clk),
        .we    (ram_we),
        .waddr ({ptr.page, commit_off}),
        .wdata (buf_q),
        .re    (ram_re),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ptr        <= '0;
            tmr        <= '0;
            have_bytes <= 1'b0;
            wr_err     <= 1'b0;
            rd_valid   <= 1'b0;
            rd_err     <= 1'b0;
        end else begin
            wr_err   <= 1'b0;
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (wr_start) begin
                        if (wr_ok) begin
                            st         <= ST_FILL;
                            ptr        <= page_ptr_t'(wr_addr);
                            have_bytes <= 1'b0;
                        end else begin
                            wr_err <= 1'b1;
                        end
                    end else if (rd_req) begin
                        rd_valid <= 1'b1;
                        rd_err   <= !rd_ok;
                    end
                end
                ST_FILL: begin
                    if (wr_byte_valid) begin
                        ptr.off    <= ptr.off + 1'b1;
                        have_bytes <= 1'b1;
                    end
                    if (wr_end) begin
                        tmr <= '0;
                        st  <= (have_bytes || wr_byte_valid) ? ST_COMMIT : ST_IDLE;
                    end
                end
                ST_COMMIT: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == TMR_LAST) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st == ST_COMMIT);
    assign rd_data = rd_err ? RD_FILL : ram_q;
endmodule

// File: rtl/zpw_ctrl_chk.sv
module zpw_ctrl_chk #(
    parameter int         WR_CYCLES = 250000,
    parameter logic [7:0] FILL      = 8'hFF
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       rd_req,
    input logic       rd_valid,
    input logic       rd_err,
    input logic [7:0] rd_data,
    input logic       wr_start,
    input logic       wr_err
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= 0;
        else              busy_run <= busy_run + 1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !rd_valid && !rd_err && !wr_err));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == WR_CYCLES);

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_run <= WR_CYCLES);

    // R6
    busy_read_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_req) |=> !rd_valid);

    // R6
    busy_start_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_start) |=> !wr_err);

    // R7
    err_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> !busy);

    // R8
    fill_on_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_err) |-> rd_data == FILL);

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));
endmodule

bind zpw_ctrl zpw_ctrl_chk #(.WR_CYCLES(WR_CYCLES), .FILL(RD_FILL)) u_zpw_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .rd_data  (rd_data),
    .wr_start (wr_start),
    .wr_err   (wr_err)
);

// File: tb/test_zpw_ctrl.sv
module test_zpw_ctrl;
    localparam int WRC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_start = 1'b0, wr_byte_valid = 1'b0, wr_end = 1'b0, rd_req = 1'b0;
    logic [9:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_byte = '0;
    logic [7:0] cfg_rd_en = 8'hFF, cfg_wr_en = 8'hFF;
    logic       busy, wr_err, rd_valid, rd_err;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [1024];

    always #10 clk = ~clk;

    zpw_ctrl #(.WR_CYCLES(WRC), .RD_FILL(8'hFF)) i_zpw_ctrl (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_byte_valid(wr_byte_valid), .wr_byte(wr_byte), .wr_end(wr_end),
        .rd_req(rd_req), .rd_addr(rd_addr), .cfg_rd_en(cfg_rd_en),
        .cfg_wr_en(cfg_wr_en), .busy(busy), .wr_err(wr_err),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
    );

    typedef struct packed {
        logic [9:0] a;
        logic [7:0] d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h005, 8'h11}, '{10'h08A, 8'h22}, '{10'h110, 8'h5A}, '{10'h180, 8'h33},
        '{10'h21F, 8'h44}, '{10'h2A3, 8'h55}, '{10'h30E, 8'h66}, '{10'h3F0, 8'h77}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input int n, input logic [7:0] d0,
                            output logic err, output int bcnt);
        logic allowed;
        allowed = cfg_wr_en[a[9:7]];
        @(negedge clk);
        wr_start = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_start = 1'b0;
        err = wr_err;
        for (int i = 0; i < n; i++) begin
            logic [3:0] o;
            o = a[3:0] + 4'(i);
            wr_byte_valid = 1'b1;
            wr_byte = d0 + 8'(i);
            if (allowed) exp_mem[{a[9:4], o}] = d0 + 8'(i);
            @(negedge clk);
        end
        wr_byte_valid = 1'b0;
        wr_end = 1'b1;
        @(negedge clk);
        wr_end = 1'b0;
        bcnt = 0;
        while (busy && bcnt < 1000) begin
            bcnt++;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [9:0] a, output logic v, output logic [7:0] d,
                           output logic e);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid; d = rd_data; e = rd_err;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic e, v, re;
        logic [7:0] d;
        int bc;

        // R1: outputs quiet during and right after reset
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 flags", {rd_valid, rd_err, wr_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after", {busy, rd_valid, rd_err, wr_err}, 0);

        // R2 R5 R11: one single-byte write per zone, then read back
        for (int k = 0; k < 8; k++) begin
            do_write(VECS[k].a, 1, VECS[k].d, e, bc);
            chk("R5 busy length", bc, WRC);
            chk("R2 no error", e, 0);
        end
        for (int k = 0; k < 8; k++) begin
            do_read(VECS[k].a, v, d, re);
            chk("R11 rd_valid", v, 1);
            chk("R2 data", {re, d}, {1'b0, VECS[k].d});
        end
        @(negedge clk);
        chk("R11 single pulse", rd_valid, 0);

        // R3: 16 bytes from offset 0xC wrap inside page 0x100
        do_write(10'h10C, 16, 8'hA0, e, bc);
        for (int i = 0; i < 16; i++) begin
            logic [9:0] a;
            a = 10'h100 + 10'(i);
            do_read(a, v, d, re);
            chk("R3 wrapped byte", d, exp_mem[a]);
        end
        do_read(10'h110, v, d, re);
        chk("R3 next page intact", d, 8'h5A);

        // R4: partial page keeps other bytes
        do_write(10'h104, 3, 8'hC0, e, bc);
        do_read(10'h103, v, d, re);
        chk("R4 below", d, exp_mem[10'h103]);
        do_read(10'h105, v, d, re);
        chk("R4 written", d, 8'hC1);
        do_read(10'h107, v, d, re);
        chk("R4 above", d, exp_mem[10'h107]);

        // R10: 18 bytes, the last two overwrite offsets 0 and 1
        do_write(10'h200, 18, 8'h10, e, bc);
        do_read(10'h200, v, d, re);
        chk("R10 offset0", d, 8'h20);
        do_read(10'h201, v, d, re);
        chk("R10 offset1", d, 8'h21);
        do_read(10'h202, v, d, re);
        chk("R10 offset2", d, 8'h12);

        // R7: write to a write-protected zone (zone 3, addr[9:7]=3)
        cfg_wr_en = 8'hF7;
        do_write(10'h180, 4, 8'hE0, e, bc);
        chk("R7 wr_err", e, 1);
        chk("R7 no busy", bc, 0);
        do_read(10'h180, v, d, re);
        chk("R7 data kept", d, 8'h33);

        // R8: read from read-protected zone 5
        cfg_rd_en = 8'hDF;
        do_read(10'h2A3, v, d, re);
        chk("R8 denied", {v, re, d}, {1'b1, 1'b1, 8'hFF});
        do_read(10'h30E, v, d, re);
        chk("R8 allowed", {v, re, d}, {1'b1, 1'b0, 8'h66});

        // R9: empty write
        do_write(10'h08A, 0, 8'h00, e, bc);
        chk("R9 no busy", bc, 0);
        chk("R9 no error", e, 0);

        // R6: commands during busy are refused
        @(negedge clk);
        wr_start = 1'b1; wr_addr = 10'h300;
        @(negedge clk);
        wr_start = 1'b0; wr_byte_valid = 1'b1; wr_byte = 8'h01;
        exp_mem[10'h300] = 8'h01;
        @(negedge clk);
        wr_byte_valid = 1'b0; wr_end = 1'b1;
        @(negedge clk);
        wr_end = 1'b0;
        chk("R6 busy up", busy, 1);
        rd_req = 1'b1; rd_addr = 10'h3F0;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R6 read refused", rd_valid, 0);
        wr_start = 1'b1; wr_addr = 10'h180;
        @(negedge clk);
        wr_start = 1'b0;
        chk("R6 start refused", wr_err, 0);
        wr_start = 1'b1; wr_addr = 10'h3F0;
        @(negedge clk);
        wr_start = 1'b0; wr_byte_valid = 1'b1; wr_byte = 8'h99;
        @(negedge clk);
        wr_byte_valid = 1'b0; wr_end = 1'b1;
        @(negedge clk);
        wr_end = 1'b0;
        while (busy) @(negedge clk);
        do_read(10'h3F0, v, d, re);
        chk("R6 memory unchanged", d, 8'h77);
        do_read(10'h300, v, d, re);
        chk("R6 accepted write", d, 8'h01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule